// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block produces the periodic bit-rate enable pulses that a UART framer consumes. All logic runs on one module clock. The two reference clocks reach it as single-cycle enable strobes: one from a crystal-derived source and one from the system clock. The selected strobe first goes through a small modulo prescaler. The prescaler divides by 4 on the system path, and by 3 or 2 on the crystal path. Its output then decrements a divisor counter of up to 23 bits. Each time that counter passes through zero it reloads and raises `tick` for one clock.

Software supplies a single configuration word:
- Bits 22:0 hold the divisor.
- Bit 23 says whether that programmed divisor or a built-in default is used.
- Bit 24 selects the crystal path.
- Bit 27 picks the divide-by-2 crystal prescale.

The divisor software writes is the rounded ratio of prescaled reference rate to baud rate, minus one. This makes the tick period exactly divisor plus one prescaled pulses. The range supports rates from 50 to 4,000,000 baud.

The word is sampled only at a counter reload. A period that has already started therefore always runs to completion with the settings it began with.

Top module: `baud_tick_gen`

## Requirements
- R1: With bit 23 of `cfg_word` set, the divisor D in bits 22:0 sets the tick period to exactly (D+1)×N pulses of the selected reference strobe, where N is the active prescale.
- R2: With bit 24 set and bit 27 clear, `xtal_ce` is the reference strobe and N is 3.
- R3: With bits 24 and 27 both set, `xtal_ce` is the reference strobe and N is 2.
- R4: With bit 24 clear, `sys_ce` is the reference strobe and N is 4, whatever the value of bit 27.
- R5: With bit 23 clear, the divisor field is ignored and the parameter DEFAULT_DIV is used in its place.
- R6: `cfg_word` is sampled only in the cycle the counter reloads, so a change made mid-period leaves the running period's length unchanged and governs the period after it.
- R7: `tick` is high for exactly one clock per period, in the cycle after the reload.
- R8: In reset `tick` is low. After reset the block runs the system path with N=4 and divisor DEFAULT_DIV until the first reload.
- R9: A divisor of 0 gives one tick every N reference pulses.
- R10: Pulses on the reference strobe that is not selected do not advance the prescaler or the divisor counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Baud configuration word: divisor, use-divisor, crystal select, divide-by-2 select |
| xtal_ce | input | 1 | One-cycle strobe marking a crystal reference edge |
| sys_ce | input | 1 | One-cycle strobe marking a system reference edge |
| tick | output | 1 | One-cycle baud enable pulse |

## Verification
The bench builds the block with DEFAULT_DIV set to 9 instead of its larger default, and leaves the divisor width at 23. This keeps the default-divisor and post-reset periods to tens of cycles, so R5 and R8 can be measured directly.

The bench drives the crystal strobe on every cycle and the system strobe on every other cycle. Because the two rates differ, a wrong source selection appears as a doubled or halved period, and every prescale value can be told apart. Divisors of 0 and small values exercise the reload boundary. A configuration write landing in the middle of a period shows whether sampling waits for the reload.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 23,
  parameter int CFG_W = 32,
  parameter int USE_BIT = 23,
  parameter int XTAL_BIT = 24,
  parameter int HALF_BIT = 27,
  parameter logic [DIV_W-1:0] DEFAULT_DIV = DIV_W'(103)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             xtal_ce,
  input  logic             sys_ce,
  output logic             tick
);

  logic             act_xtal, act_half;
  logic [1:0]       pre_cnt;
  logic [DIV_W-1:0] div_cnt;

  logic             sel_ce, pre_pulse, reload;
  logic [1:0]       pre_top;
  logic [DIV_W-1:0] next_div;
  logic             unused_cfg;

  assign sel_ce    = act_xtal ? xtal_ce : sys_ce;
  assign pre_top   = !act_xtal ? 2'd3 : (act_half ? 2'd1 : 2'd2);
  assign pre_pulse = sel_ce && (pre_cnt == pre_top);
  assign reload    = pre_pulse && (div_cnt == '0);
  assign next_div  = cfg_word[USE_BIT] ? cfg_word[DIV_W-1:0] : DEFAULT_DIV;
  assign unused_cfg = ^cfg_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      div_cnt  <= DEFAULT_DIV;
      act_xtal <= 1'b0;
      act_half <= 1'b0;
      tick     <= 1'b0;
    end else begin
      tick <= reload;
      if (sel_ce)
        pre_cnt <= pre_pulse ? 2'd0 : pre_cnt + 2'd1;
      if (reload) begin
        div_cnt  <= next_div;
        act_xtal <= cfg_word[XTAL_BIT];
        act_half <= cfg_word[HALF_BIT];
      end else if (pre_pulse) begin
        div_cnt <= div_cnt - 1'b1;
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_top); // R1

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_pulse |=> $stable(div_cnt)); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(act_xtal) && $stable(act_half))); // R6

  AST_IDLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ce |=> $stable(pre_cnt)); // R10

endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic        xtal_ce = 1'b0;
  logic        sys_ce = 1'b0;
  logic        xtal_gate = 1'b1;
  logic        tick;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  baud_tick_gen #(.DEFAULT_DIV(23'd9)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .xtal_ce(xtal_ce), .sys_ce(sys_ce), .tick(tick)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sys_ce  <= rst_n ? ~sys_ce : 1'b0;
    xtal_ce <= xtal_gate;
  end

  localparam int NV = 9;
  localparam logic [31:0] VCFG [NV] = '{
    32'h0000_0000, 32'h0080_0004, 32'h0880_0004, 32'h0180_0004,
    32'h0980_0004, 32'h0180_0000, 32'h0980_0000, 32'h0100_0007,
    32'h0180_0010 };
  localparam int VEXP [NV] = '{80, 40, 40, 15, 10, 3, 2, 30, 51};

  function automatic string tag_of(int i);
    case (i)
      0: return "R5";
      1: return "R1";
      2: return "R4";
      3: return "R2";
      4: return "R3";
      5: return "R9";
      6: return "R9";
      7: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (tick !== 1'b1);
    t = cyc;
  endtask

  initial begin
    int t0, t1, t2, seen;
    repeat (4) @(negedge clk);
    check("R8", int'(tick), 0);
    rst_n = 1'b1;
    t0 = cyc;
    wait_tick(t1);
    total++;
    if (t1 - t0 < 78 || t1 - t0 > 82) begin
      bad++;
      $display("FAIL R8 actual=%0d expected=80", t1 - t0);
    end

    for (int i = 0; i < NV; i++) begin
      cfg_word = VCFG[i];
      wait_tick(t0);
      @(negedge clk);
      check("R7", int'(tick), 0);
      wait_tick(t1);
      check(tag_of(i), t1 - t0, VEXP[i]);
    end

    // R6: a mid-period write does not alter the running period
    cfg_word = 32'h0180_0004;
    wait_tick(t0);
    repeat (3) @(negedge clk);
    cfg_word = 32'h0980_0000;
    wait_tick(t1);
    check("R6", t1 - t0, 15);
    wait_tick(t2);
    check("R6", t2 - t1, 2);

    // R10: stop the crystal strobe; sys_ce keeps toggling
    xtal_gate = 1'b0;
    repeat (2) @(negedge clk);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check("R10", seen, 0);
    xtal_gate = 1'b1;
    wait_tick(t0);
    wait_tick(t1);
    check("R10", t1 - t0, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule